// File: doc/BRIEF.md
# Rotational Frequency Roller Controller

This block follows a bang-bang phase detector in a single-loop clock recovery path. In each sampling cycle it receives the detector's lead/lag flag, two flags that show whether the falling or the rising clock edge landed inside the middle third of a data bit, and the raw up/down decision. While the recovered clock slips against the data, it exchanges the up and down outputs. A clock that runs too fast or too slow then produces a decision of one sign, rather than one that alternates. The loop can therefore acquire frequency without a second loop.

A five-state machine tracks the slip. The states are `RS_IDLE`, `RS_FAST_ARM`, `RS_SLOW_ARM`, `RS_ROLL_FAST` and `RS_ROLL_SLOW`. The transitions are:

- **Fast arm:** `RS_IDLE` moves to `RS_FAST_ARM` on a falling-edge window hit while the lead flag is high.
- **Fast roll:** `RS_FAST_ARM` moves to `RS_ROLL_FAST` when the lead flag drops.
- **Fast exit:** `RS_ROLL_FAST` returns to `RS_IDLE` on a rising-edge window hit while the lead flag is high.
- **Slow arm:** `RS_IDLE` moves to `RS_SLOW_ARM` on a falling-edge window hit while the lead flag is low.
- **Slow roll:** `RS_SLOW_ARM` moves to `RS_ROLL_SLOW` when the lead flag rises.
- **Slow exit:** `RS_ROLL_SLOW` returns to `RS_IDLE` when the lead flag drops.

Every other input combination holds the present state. Once the frequency error is gone, the machine remains in `RS_IDLE` and the raw decision passes through unchanged.

Top module: `freq_roller`

## Requirements
- R1: A synchronous active-low reset sampled at a rising clock edge returns the machine to `RS_IDLE`, so `roll_o` is 0 from the next cycle.
- R2: While `roll_o` is 0 and exactly one of `raw_up_i`/`raw_dn_i` is 1, `up_o` equals `raw_up_i` and `dn_o` equals `raw_dn_i` in the same cycle; `up_o` and `dn_o` are never 1 together.
- R3: When `raw_up_i` equals `raw_dn_i` (no transition, or an invalid pair), `up_o` and `dn_o` are both 0 whatever the roll state.
- R4: From `RS_IDLE`, a cycle with `fall_win_i`=1 and `lead_i`=1 arms the fast sequence. A later cycle with `lead_i`=0 then sets `roll_o` to 1 from the following cycle.
- R5: From `RS_IDLE`, a cycle with `fall_win_i`=1 and `lead_i`=0 arms the slow sequence. A later cycle with `lead_i`=1 then sets `roll_o` to 1 from the following cycle.
- R6: An armed sequence stays armed, with `roll_o` 0, for as long as `lead_i` keeps the level it had when arming; window flags have no effect while armed.
- R7: A fast roll keeps `roll_o` at 1 through every cycle that is not a rising-edge window hit with `lead_i`=1; such a hit makes `roll_o` 0 from the next cycle.
- R8: A slow roll keeps `roll_o` at 1 while `lead_i` is 1, and ends, with `roll_o` 0 from the next cycle, on the first cycle with `lead_i`=0, whatever the window flags.
- R9: While `roll_o` is 1 and exactly one raw flag is set, `up_o` equals `raw_dn_i` and `dn_o` equals `raw_up_i`.
- R10: After a roll ends, both sequence flags are clear, and the very next falling-edge window hit starts a new arm.
- R11: In `RS_IDLE`, a cycle with `fall_win_i`=0 leaves `roll_o` at 0 and does not arm, even when `rise_win_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lead_i | input | 1 | 1 when the rising clock edge leads the falling edge |
| fall_win_i | input | 1 | Falling clock edge landed inside the middle-third window |
| rise_win_i | input | 1 | Rising clock edge landed inside the middle-third window |
| raw_up_i | input | 1 | Raw up decision from the phase detector |
| raw_dn_i | input | 1 | Raw down decision from the phase detector |
| up_o | output | 1 | Corrected up decision |
| dn_o | output | 1 | Corrected down decision |
| roll_o | output | 1 | 1 while the decision is being exchanged |

## Verification
The state register is the only register in the path. A sample that triggers a transition therefore changes `roll_o` one cycle later, and `up_o`/`dn_o` follow the raw inputs in the same cycle, steered by the current state. The bench drives inputs at the falling clock edge and compares all three outputs shortly afterwards, before the next rising edge, against a reference model. It advances that model only after the rising edge, so each comparison sees exactly one state update. Directed sequences cover both roll paths, arming hold, immediate re-arming and reset during a roll. A seeded random run mixes slowly changing lead levels with window hits.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

    typedef enum logic [2:0] {
        RS_IDLE      = 3'd0,
        RS_FAST_ARM  = 3'd1,
        RS_SLOW_ARM  = 3'd2,
        RS_ROLL_FAST = 3'd3,
        RS_ROLL_SLOW = 3'd4
    } roll_state_t;

    localparam int unsigned DEC_W = 2;

endpackage

// File: rtl/rfr_seq.sv
module rfr_seq
    import rfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lead_i,
    input  logic        fall_win_i,
    input  logic        rise_win_i,
    output roll_state_t state_o,
    output logic        roll_o
);

    roll_state_t state_q;
    roll_state_t state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: begin
                if (fall_win_i) begin
                    state_d = lead_i ? RS_FAST_ARM : RS_SLOW_ARM;
                end
            end
            RS_FAST_ARM: begin
                if (!lead_i) begin
                    state_d = RS_ROLL_FAST;
                end
            end
            RS_SLOW_ARM: begin
                if (lead_i) begin
                    state_d = RS_ROLL_SLOW;
                end
            end
            RS_ROLL_FAST: begin
                if (rise_win_i && lead_i) begin
                    state_d = RS_IDLE;
                end
            end
            RS_ROLL_SLOW: begin
                if (!lead_i) begin
                    state_d = RS_IDLE;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        unique case (state_q)
            RS_ROLL_FAST, RS_ROLL_SLOW: roll_o = 1'b1;
            default:                    roll_o = 1'b0;
        endcase
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == RS_IDLE));

    // R4
    fast_roll_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_FAST_ARM && !lead_i) |=> roll_o);

    // R5
    slow_roll_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_SLOW_ARM && lead_i) |=> roll_o);

    // R6
    fast_arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_FAST_ARM && lead_i) |=> (state_q == RS_FAST_ARM && !roll_o));

    // R6
    slow_arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_SLOW_ARM && !lead_i) |=> (state_q == RS_SLOW_ARM && !roll_o));

    // R7
    fast_roll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_ROLL_FAST && !(rise_win_i && lead_i)) |=> roll_o);

    // R7
    fast_roll_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_ROLL_FAST && rise_win_i && lead_i) |=> !roll_o);

    // R8
    slow_roll_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_ROLL_SLOW && !lead_i) |=> (state_q == RS_IDLE));

    // R11
    idle_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_IDLE && !fall_win_i) |=> (state_q == RS_IDLE && !roll_o));

endmodule

// File: rtl/rfr_steer.sv
module rfr_steer
    import rfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_up_i,
    input  logic raw_dn_i,
    input  logic roll_i,
    output logic up_o,
    output logic dn_o
);

    logic [DEC_W-1:0] raw_pair;
    logic [DEC_W-1:0] out_pair;

    assign raw_pair = {raw_up_i, raw_dn_i};

    always_comb begin
        unique case (raw_pair)
            2'b10:   out_pair = roll_i ? 2'b01 : 2'b10;
            2'b01:   out_pair = roll_i ? 2'b10 : 2'b01;
            default: out_pair = 2'b00;
        endcase
    end

    assign up_o = out_pair[1];
    assign dn_o = out_pair[0];

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_o && dn_o));

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!roll_i && (raw_up_i != raw_dn_i)) |-> (up_o == raw_up_i && dn_o == raw_dn_i));

    // R3
    null_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_up_i == raw_dn_i) |-> (!up_o && !dn_o));

    // R9
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_i && (raw_up_i != raw_dn_i)) |-> (up_o == raw_dn_i && dn_o == raw_up_i));

endmodule

// File: rtl/freq_roller.sv
module freq_roller
    import rfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lead_i,
    input  logic fall_win_i,
    input  logic rise_win_i,
    input  logic raw_up_i,
    input  logic raw_dn_i,
    output logic up_o,
    output logic dn_o,
    output logic roll_o
);

    roll_state_t seq_state;
    logic        seq_roll;

    rfr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .lead_i     (lead_i),
        .fall_win_i (fall_win_i),
        .rise_win_i (rise_win_i),
        .state_o    (seq_state),
        .roll_o     (seq_roll)
    );

    rfr_steer u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_up_i (raw_up_i),
        .raw_dn_i (raw_dn_i),
        .roll_i   (seq_roll),
        .up_o     (up_o),
        .dn_o     (dn_o)
    );

    assign roll_o = seq_roll;

    // R10
    exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(roll_o) |-> (seq_state == RS_IDLE));

endmodule

// File: tb/freq_roller_bench.sv
`timescale 1ns/1ps
module freq_roller_bench;

    localparam int M_IDLE = 0;
    localparam int M_FA   = 1;
    localparam int M_SA   = 2;
    localparam int M_RF   = 3;
    localparam int M_RS   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lead = 1'b0;
    logic fall_w = 1'b0;
    logic rise_w = 1'b0;
    logic rup = 1'b0;
    logic rdn = 1'b0;
    logic up, dn, roll;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int m_st = M_IDLE;
    string m_reason = "R1";
    bit just_exit = 1'b0;

    always #2.5 clk = ~clk;

    freq_roller u_freq_roller (
        .clk        (clk),
        .rst_n      (rst_n),
        .lead_i     (lead),
        .fall_win_i (fall_w),
        .rise_win_i (rise_w),
        .raw_up_i   (rup),
        .raw_dn_i   (rdn),
        .up_o       (up),
        .dn_o       (dn),
        .roll_o     (roll)
    );

    function automatic bit m_rolling(input int st);
        return (st == M_RF) || (st == M_RS);
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic model_step(input bit r, input bit l, input bit f, input bit rw);
        bit exited = 1'b0;
        if (!r) begin
            m_st = M_IDLE;
            m_reason = "R1";
        end else begin
            case (m_st)
                M_IDLE: begin
                    if (f) begin
                        m_st = l ? M_FA : M_SA;
                        m_reason = just_exit ? "R10" : (l ? "R4" : "R5");
                    end else begin
                        m_reason = "R11";
                    end
                end
                M_FA: begin
                    if (!l) begin m_st = M_RF; m_reason = "R4"; end
                    else m_reason = "R6";
                end
                M_SA: begin
                    if (l) begin m_st = M_RS; m_reason = "R5"; end
                    else m_reason = "R6";
                end
                M_RF: begin
                    if (rw && l) begin m_st = M_IDLE; exited = 1'b1; end
                    m_reason = "R7";
                end
                default: begin
                    if (!l) begin m_st = M_IDLE; exited = 1'b1; end
                    m_reason = "R8";
                end
            endcase
        end
        just_exit = exited;
    endtask

    task automatic cyc(input bit r, input bit l, input bit f, input bit rw,
                       input bit u, input bit d, input bit do_chk);
        logic eu, ed;
        @(negedge clk);
        rst_n = r; lead = l; fall_w = f; rise_w = rw; rup = u; rdn = d;
        #1;
        if (do_chk) begin
            check(m_reason, "roll_o", roll, m_rolling(m_st));
            if (u == d) begin
                check("R3", "up_o", up, 1'b0);
                check("R3", "dn_o", dn, 1'b0);
            end else if (m_rolling(m_st)) begin
                check("R9", "up_o", up, d);
                check("R9", "dn_o", dn, u);
            end else begin
                check("R2", "up_o", up, u);
                check("R2", "dn_o", dn, d);
            end
        end
        @(posedge clk);
        model_step(r, l, f, rw);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit l;
        l = 1'b0;
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 1);          // R1 reset state, R2 pass
        // R11: rise-window hits in idle do nothing
        cyc(1, 1, 0, 1, 0, 1, 1);
        cyc(1, 0, 0, 1, 1, 1, 1);          // R3 null
        // R4 fast sequence, R6 hold, R7 roll/exit, R9 swap
        cyc(1, 1, 1, 0, 1, 0, 1);
        cyc(1, 1, 1, 1, 0, 1, 1);
        cyc(1, 0, 0, 0, 1, 0, 1);
        cyc(1, 0, 1, 1, 1, 0, 1);
        cyc(1, 1, 0, 0, 0, 1, 1);
        cyc(1, 1, 0, 1, 0, 0, 1);
        // R10 immediate re-arm, slow this time
        cyc(1, 0, 1, 0, 1, 0, 1);
        cyc(1, 0, 1, 1, 0, 1, 1);
        cyc(1, 1, 0, 0, 1, 0, 1);          // R5 roll on
        cyc(1, 1, 1, 1, 1, 0, 1);          // R8 hold with windows
        cyc(1, 0, 1, 1, 0, 1, 1);          // R8 exit
        cyc(1, 0, 0, 0, 0, 1, 1);
        // R1 reset during a roll
        cyc(1, 1, 1, 0, 1, 0, 1);
        cyc(1, 0, 0, 0, 1, 0, 1);
        cyc(0, 0, 0, 0, 1, 0, 1);
        cyc(1, 0, 0, 0, 1, 0, 1);
        cyc(1, 0, 0, 0, 0, 1, 1);
        // seeded random run
        void'($urandom(32'h5EED_2024));
        for (int i = 0; i < 4000; i++) begin
            bit f, rw, u, d, r;
            if (($urandom % 4) == 0) l = ~l;
            f  = (($urandom % 3) == 0);
            rw = (($urandom % 3) == 0);
            u  = $urandom % 2;
            d  = $urandom % 2;
            r  = (($urandom % 200) != 0);
            cyc(r, l, f, rw, u, d, 1);
        end
        finish_run();
    end

endmodule